// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block gathers eight single-cycle event pulses from a serial flash controller and turns them into the registers a host uses to service interrupts. The sources are the FIFOs, the command engine, the bus interface and the DMA engine. Each pulse sets a sticky raw status bit.

A mask register selects which latched bits may reach the single level-sensitive interrupt line. A set mask bit blocks its source. Software clears a latched bit by writing a one to it through the clear register.

The host side is a plain register port: a write strobe with an address and data, and read data that follows the address combinationally. Reads have no side effects.

Source bit positions are fixed:

| Bit | Source |
|-----|--------|
| 0 | receive full |
| 1 | receive underflow |
| 2 | transmit overflow |
| 3 | transmit empty |
| 4 | transfer finish |
| 5 | bus error |
| 6 | non-SPI error |
| 7 | DMA done |

Register selects are 0 mask, 1 clear, 2 raw status and 3 masked status.

Top module: `irq_status_unit`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the mask reads all ones, raw and masked status read zero, and irq_o is low.
- R2: A pulse on evt_i[i] sets raw status bit i at the next clock edge, and the bit stays set until it is cleared.
- R3: Raw status latches events whose mask bit is 1, and such a bit does not raise irq_o or appear in masked status.
- R4: A write to select 0 loads the mask from the write data. A 1 disables the matching source and a 0 enables it. Masked status (select 3) reads raw status AND NOT mask.
- R5: irq_o is high exactly when any masked status bit is 1.
- R6: A write to select 1 clears every raw bit whose data bit is 1, and leaves the bits whose data bit is 0 unchanged.
- R7: If an event on bit i arrives in the same cycle as a clear of bit i, bit i is set after the edge.
- R8: Writes to select 2 or select 3 change nothing, and select 1 reads as zero.
- R9: The 2-bit register select decodes as 0 mask, 1 clear, 2 raw status, 3 masked status. Read data follows the select within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 8 | Event pulses, one bit per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Level interrupt, OR of masked status |

## Verification
The bench latches an event while its source is masked and checks that the raw bit is set while the interrupt stays low. A design that gated latching with the mask would lose the event. A design with inverted mask polarity would raise the interrupt here.

The bench writes zero data to the clear register, which must not disturb any bit. It then writes a full clear in the same cycle as an event on one bit, where a clear-wins design would drop the event.

Writes aimed at the two read-only status selects must leave the state unchanged. A sloppy decoder would overwrite the mask or clear bits on those writes.

// File: rtl/irq_pkg.sv
// Shared definitions for the interrupt status unit.
// Assumes a 2-bit register select; encodings are part of the host contract.
package irq_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK   = 2'd0,
        SEL_CLEAR  = 2'd1,
        SEL_RAW    = 2'd2,
        SEL_MASKED = 2'd3
    } regsel_e;
endpackage

// File: rtl/irq_reg_decode.sv
// Decodes the host write strobe into a mask load enable and a clear vector.
// Assumes writes to the status selects are to be ignored.
module irq_reg_decode
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [NUM_SRC-1:0]   wdata_i,
    output logic                 mask_we_o,
    output logic [NUM_SRC-1:0]   clr_vec_o
);
    // Steer the write toward the mask or the clear vector by select.
    always_comb begin
        mask_we_o = wr_i && (regsel_e'(addr_i) == SEL_MASK);
        clr_vec_o = (wr_i && (regsel_e'(addr_i) == SEL_CLEAR)) ? wdata_i : '0;
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Holds the source mask; a set bit disables that source.
// Resets to all ones so no source can interrupt before software opts in.
module irq_mask_reg #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] mask_o
);
    // Load the mask on a decoded write, all-ones on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '1;
        else if (we_i)
            mask_o <= wdata_i;
    end
endmodule

// File: rtl/irq_sticky_bank.sv
// One sticky status flop per source, set by an event pulse, cleared by write-one.
// Assumes events are single-cycle; a coincident event beats a clear.
module irq_sticky_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] raw_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        // Per-source latch: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                raw_o[g] <= 1'b0;
            else if (evt_i[g])
                raw_o[g] <= 1'b1;
            else if (clr_i[g])
                raw_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_read_mux.sv
// Selects the register view returned to the host; the clear register reads zero.
// Purely combinational, no read side effects.
module irq_read_mux
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] raw_i,
    input  logic [NUM_SRC-1:0] masked_i,
    output logic [NUM_SRC-1:0] rdata_o
);
    // Pick the read value by select.
    always_comb begin
        unique case (regsel_e'(addr_i))
            SEL_MASK:   rdata_o = mask_i;
            SEL_CLEAR:  rdata_o = '0;
            SEL_RAW:    rdata_o = raw_i;
            SEL_MASKED: rdata_o = masked_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_unit.sv
// Top of the interrupt status unit: sticky raw status, inverted-polarity mask,
// write-one-to-clear, masked view and a single level interrupt.
// Assumes event pulses and host writes share one clock.
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               irq_o
);
    logic               mask_we;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] masked;

    irq_reg_decode #(.NUM_SRC(NUM_SRC)) u_dec (
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .mask_we_o (mask_we),
        .clr_vec_o (clr_vec)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_q)
    );

    irq_sticky_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .clr_i (clr_vec),
        .raw_o (raw_q)
    );

    // Gate latched status with the enabled sources and combine into the line.
    always_comb begin
        masked = raw_q & ~mask_q;
        irq_o  = |masked;
    end

    irq_read_mux #(.NUM_SRC(NUM_SRC)) u_rd (
        .addr_i   (reg_addr_i),
        .mask_i   (mask_q),
        .raw_i    (raw_q),
        .masked_i (masked),
        .rdata_o  (reg_rdata_o)
    );
endmodule

// File: rtl/irq_status_chk.sv
// Temporal checks on the interrupt status unit, attached by bind.
// Uses the unit's ports plus its mask and raw state.
module irq_status_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               reg_wr_i,
    input logic [1:0]         reg_addr_i,
    input logic [NUM_SRC-1:0] reg_wdata_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] raw_q
);
    logic [NUM_SRC-1:0] chk_clr;
    logic               chk_mask_wr;
    logic               seen_reset;

    // Independent view of what the host asked to clear or load.
    always_comb begin
        chk_clr     = (reg_wr_i && reg_addr_i == 2'd1) ? reg_wdata_i : '0;
        chk_mask_wr = reg_wr_i && reg_addr_i == 2'd0;
    end

    // Marks that at least one reset edge has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_reset <= 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_reset && $rose(rst_n)) |-> (mask_q == '1 && raw_q == '0 && !irq_o));

    // R2
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q != '0) |=> ((raw_q & ($past(raw_q) & ~$past(chk_clr))) ==
                           ($past(raw_q) & ~$past(chk_clr))));

    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_clr != '0) |=> ((raw_q & $past(chk_clr & ~evt_i)) == '0));

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !chk_mask_wr && ((evt_i & ~mask_q) == '0)) |=> !irq_o);

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_q != '1 && raw_q != '0));
endmodule

bind irq_status_unit irq_status_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .mask_q      (mask_q),
    .raw_q       (raw_q)
);

// File: tb/sim_irq_status_unit.sv
// Scoreboard bench: the driver pushes expected read and interrupt values,
// the monitor pops and compares them before the next rising edge.
module sim_irq_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt = '0;
    logic       wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       irq;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    logic [7:0] m_mask = 8'hFF;
    logic [7:0] m_raw  = 8'h00;
    logic       done   = 1'b0;

    always #4 clk = ~clk;

    irq_status_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Expected read value from the requirement-level model.
    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_mask;
            2'd1:    return 8'h00;
            2'd2:    return m_raw;
            default: return m_raw & ~m_mask;
        endcase
    endfunction

    // Drive one cycle; optionally queue the expected view before the edge.
    task automatic cyc(input string tag, input logic chk, input logic [7:0] e,
                       input logic w, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        evt = e; wr = w; addr = a; wdata = d;
        if (chk) exp_q.push_back('{tag, model_read(a), |(m_raw & ~m_mask)});
        @(posedge clk);
        m_raw = e | (m_raw & ~((w && a == 2'd1) ? d : 8'h00));
        if (w && a == 2'd0) m_mask = d;
    endtask

    task automatic look(input string tag, input logic [1:0] a);
        cyc(tag, 1'b1, 8'h00, 1'b0, a, 8'h00);
    endtask

    // Monitor: compare each queued item shortly after the falling edge.
    always @(negedge clk) begin
        #2;
        while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (rdata !== it.rd || irq !== it.irq) begin
                n_fail++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.tag, rdata, irq, it.rd, it.irq);
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset view
        look("R1 mask", 2'd0);
        look("R1 raw", 2'd2);
        look("R1 masked", 2'd3);
        // R3 event latched while masked, no interrupt
        cyc("R3", 1'b0, 8'h01, 1'b0, 2'd0, 8'h00);
        look("R3 raw", 2'd2);
        look("R3 masked", 2'd3);
        // R4 R5 enable low nibble
        cyc("R4", 1'b0, 8'h00, 1'b1, 2'd0, 8'hF0);
        look("R4 masked", 2'd3);
        look("R5 mask", 2'd0);
        // R6 zero-data clear leaves bits
        cyc("R6", 1'b0, 8'h00, 1'b1, 2'd1, 8'h00);
        look("R6 raw keep", 2'd2);
        // R6 clear bit 0
        cyc("R6", 1'b0, 8'h00, 1'b1, 2'd1, 8'h01);
        look("R6 raw cleared", 2'd2);
        // R2 several sources at once, sticky over idle cycles
        cyc("R2", 1'b0, 8'hA5, 1'b0, 2'd0, 8'h00);
        cyc("R2", 1'b0, 8'h00, 1'b0, 2'd0, 8'h00);
        look("R2 raw", 2'd2);
        look("R2 masked", 2'd3);
        // R7 event and full clear together
        cyc("R7", 1'b0, 8'h04, 1'b1, 2'd1, 8'hFF);
        look("R7 raw", 2'd2);
        look("R7 masked", 2'd3);
        // R8 writes to status selects ignored, clear reads zero
        cyc("R8", 1'b0, 8'h00, 1'b1, 2'd2, 8'hFF);
        cyc("R8", 1'b0, 8'h00, 1'b1, 2'd3, 8'h00);
        look("R8 raw", 2'd2);
        look("R8 mask", 2'd0);
        look("R8 clear reads", 2'd1);
        // R9 mask-only source raises the line after unmasking, select map
        cyc("R9", 1'b0, 8'h00, 1'b1, 2'd1, 8'hFF);
        cyc("R9", 1'b0, 8'h80, 1'b0, 2'd0, 8'h00);
        look("R9 masked", 2'd3);
        cyc("R9", 1'b0, 8'h00, 1'b1, 2'd0, 8'h7F);
        look("R9 masked", 2'd3);
        look("R9 raw", 2'd2);
        // R5 remask everything drops the line
        cyc("R5", 1'b0, 8'h00, 1'b1, 2'd0, 8'hFF);
        look("R5 off", 2'd3);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule